// File: doc/BRIEF.md
# Lock-Step Handshake Fork

This block takes one valid/ready channel whose payload is a bundle of several fields and splits it into one valid/ready channel per field. The bundle is treated as indivisible: the producer sees ready only when every consumer can take its field, and each consumer sees valid only when the producer has data and every other consumer is ready. All consumers therefore accept their fields in the same cycle, and no field of a bundle is ever taken while a sibling field waits.

The block is purely combinational. The number of branches and the field width are parameters. A grouping parameter selects either a flat fork or a nested one. In the nested form, the first few branches sit behind an inner fork, which in turn hangs off one branch of an outer fork, as in ((A,B),C). The handshake seen at the ports is the same in both forms. The block is meant to sit between registered stages. A consumer whose ready depends on its own valid would close a combinational loop through the fork.

Top module: `lockstep_fork`

## Requirements
- R1: `ready_o` is high exactly when every bit of `ready_i` is high.
- R2: `valid_o[i]` is high exactly when `valid_i` is high and the ready bit of every branch other than `i` is high.
- R3: In any cycle, either every branch completes a handshake (`valid_o[i]` and `ready_i[i]` both high) together with the upstream one (`valid_i` and `ready_o` both high), or none of them does.
- R4: Branch 0 carries the most significant field. Branch `i` receives bits `[(N_BR-i)*DATA_W-1 -: DATA_W]` of `data_i` on `data_o` at the same bit positions, whatever the handshake state.
- R5: While `valid_i` is low, all `valid_o` bits are low, for any `ready_i`.
- R6: A branch's own ready bit has no effect on its own `valid_o`.
- R7: The nested grouping (`INNER_N` >= 2) produces the same valid/ready behaviour at the ports as the flat fork of `N_BR` branches.
- R8: Every output follows its inputs with no clock edge, and every upstream bundle reaches each branch exactly once, in the same cycle for all branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N_BR*DATA_W | Upstream bundle, branch 0 in the upper field |
| valid_i | input | 1 | Upstream bundle is valid |
| ready_o | output | 1 | Upstream bundle may be consumed |
| data_o | output | N_BR*DATA_W | Per-branch fields, branch i at the same position as in data_i |
| valid_o | output | N_BR | Per-branch valid, bit i for branch i |
| ready_i | input | N_BR | Per-branch ready, bit i for branch i |

## Verification
The assertions assume that the inputs are stable when they are evaluated. They also assume that no consumer derives its ready from its own valid, because that would make the fork's outputs oscillate rather than settle. The bench drives `valid_i` and `ready_i` only from its own state and from fixed patterns, never from `valid_o`. It changes them between clock edges and samples once they have settled. This keeps every case free of loops and still covers all combinations of valid and ready for three branches.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  // LSB of branch idx's field; branch 0 sits in the upper field
  function automatic int fld_lsb(input int idx, input int n, input int w);
    return (n - 1 - idx) * w;
  endfunction
endpackage

// File: rtl/lsf_others_and.sv
module lsf_others_and #(
  parameter int N = 3
) (
  input  logic [N-1:0] bit_i,
  output logic [N-1:0] others_o,
  output logic         all_o
);
  logic [N:0] pre;
  logic [N:0] suf;

  assign pre[0] = 1'b1;
  assign suf[N] = 1'b1;

  for (genvar g = 0; g < N; g++) begin : g_scan
    assign pre[g+1] = pre[g] & bit_i[g];
    assign suf[g]   = suf[g+1] & bit_i[g];
    assign others_o[g] = pre[g] & suf[g+1];
  end

  assign all_o = pre[N];
endmodule

// File: rtl/lsf_hs_fork.sv
module lsf_hs_fork #(
  parameter int N = 3
) (
  input  logic         valid_i,
  output logic         ready_o,
  output logic [N-1:0] valid_o,
  input  logic [N-1:0] ready_i
);
  logic [N-1:0] others_rdy;

  lsf_others_and #(.N(N)) u_and (
    .bit_i    (ready_i),
    .others_o (others_rdy),
    .all_o    (ready_o)
  );

  assign valid_o = {N{valid_i}} & others_rdy;
endmodule

// File: rtl/lsf_split.sv
module lsf_split #(
  parameter int N      = 3,
  parameter int DATA_W = 8
) (
  input  logic [N*DATA_W-1:0] data_i,
  output logic [N*DATA_W-1:0] data_o
);
  import lsf_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_fld
    localparam int Lsb = fld_lsb(g, N, DATA_W);
    assign data_o[Lsb +: DATA_W] = data_i[Lsb +: DATA_W];
  end
endmodule

// File: rtl/lockstep_fork.sv
module lockstep_fork #(
  parameter int N_BR    = 3,
  parameter int DATA_W  = 8,
  parameter int INNER_N = 2   // branches 0..INNER_N-1 grouped behind an inner fork; <2 = flat
) (
  input  logic [N_BR*DATA_W-1:0] data_i,
  input  logic                   valid_i,
  output logic                   ready_o,
  output logic [N_BR*DATA_W-1:0] data_o,
  output logic [N_BR-1:0]        valid_o,
  input  logic [N_BR-1:0]        ready_i
);
  localparam bit Nested  = (INNER_N >= 2) && (INNER_N < N_BR);
  localparam int OuterN  = Nested ? (N_BR - INNER_N + 1) : N_BR;

  lsf_split #(.N(N_BR), .DATA_W(DATA_W)) u_split (
    .data_i (data_i),
    .data_o (data_o)
  );

  if (Nested) begin : g_nested
    logic [OuterN-1:0]  outer_v;
    logic [OuterN-1:0]  outer_r;
    logic               inner_up_r;
    logic [INNER_N-1:0] inner_v;

    assign outer_r = {ready_i[N_BR-1:INNER_N], inner_up_r};

    lsf_hs_fork #(.N(OuterN)) u_outer (
      .valid_i (valid_i),
      .ready_o (ready_o),
      .valid_o (outer_v),
      .ready_i (outer_r)
    );

    lsf_hs_fork #(.N(INNER_N)) u_inner (
      .valid_i (outer_v[0]),
      .ready_o (inner_up_r),
      .valid_o (inner_v),
      .ready_i (ready_i[INNER_N-1:0])
    );

    assign valid_o = {outer_v[OuterN-1:1], inner_v};
  end else begin : g_flat
    lsf_hs_fork #(.N(N_BR)) u_fork (
      .valid_i (valid_i),
      .ready_o (ready_o),
      .valid_o (valid_o),
      .ready_i (ready_i)
    );
  end
endmodule

// File: rtl/lsf_checker.sv
module lsf_checker #(
  parameter int N_BR   = 3,
  parameter int DATA_W = 8
) (
  input logic [N_BR*DATA_W-1:0] data_i,
  input logic                   valid_i,
  input logic                   ready_o,
  input logic [N_BR*DATA_W-1:0] data_o,
  input logic [N_BR-1:0]        valid_o,
  input logic [N_BR-1:0]        ready_i
);
  logic [N_BR-1:0] fire;
  logic            up_fire;

  assign fire    = valid_o & ready_i;
  assign up_fire = valid_i & ready_o;

  always_comb begin
    AST_READY_ALL: assert (ready_o == (ready_i == '1)); // R1
    AST_NO_PARTIAL: assert ((fire == '0 && !up_fire) || (fire == '1 && up_fire)); // R3
    AST_DATA_PASS: assert (data_o == data_i); // R4
    AST_IDLE_SILENT: assert (valid_i || valid_o == '0); // R5
    for (int i = 0; i < N_BR; i++) begin
      AST_VALID_GATED: assert (valid_o[i] == (valid_i && ((ready_i | (N_BR'(1) << i)) == '1))); // R2
    end
  end
endmodule

bind lockstep_fork lsf_checker #(.N_BR(N_BR), .DATA_W(DATA_W)) u_chk (
  .data_i  (data_i),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .data_o  (data_o),
  .valid_o (valid_o),
  .ready_i (ready_i)
);

// File: tb/sim_lockstep_fork.sv
module sim_lockstep_fork;
  localparam int N = 3;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [N*W-1:0] data_i;
  logic         valid_i;
  logic         ready_o;
  logic [N*W-1:0] data_o;
  logic [N-1:0] valid_o;
  logic [N-1:0] ready_i;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lockstep_fork #(.N_BR(N), .DATA_W(W), .INNER_N(2)) u0 (
    .data_i (data_i), .valid_i (valid_i), .ready_o (ready_o),
    .data_o (data_o), .valid_o (valid_o), .ready_i (ready_i)
  );

  // {valid_i, ready_i[2:0], exp valid_o[2:0], exp ready_o}
  localparam logic [7:0] VEC [16] = '{
    8'b0_000_000_0, 8'b0_001_000_0, 8'b0_010_000_0, 8'b0_011_000_0,
    8'b0_100_000_0, 8'b0_101_000_0, 8'b0_110_000_0, 8'b0_111_000_1,
    8'b1_000_000_0, 8'b1_001_000_0, 8'b1_010_000_0, 8'b1_011_100_0,
    8'b1_100_000_0, 8'b1_101_010_0, 8'b1_110_001_0, 8'b1_111_111_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  logic [N*W-1:0] words [8];
  int src_idx;
  int rcv [N];

  initial begin
    data_i = '0; valid_i = 1'b0; ready_i = '0;
    @(negedge clk); #1;
    // idle state
    chk("R5 idle valid_o", 32'(valid_o), 0);
    chk("R1 idle ready_o", 32'(ready_o), 0);

    // full valid/ready table, nested build must match flat rule
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      valid_i = VEC[k][7];
      ready_i = VEC[k][6:4];
      #1;
      chk("R2/R7 valid_o", 32'(valid_o), 32'(VEC[k][3:1]));
      chk("R1/R7 ready_o", 32'(ready_o), 32'(VEC[k][0]));
    end

    // R6: toggling own ready leaves own valid unchanged
    @(negedge clk);
    valid_i = 1'b1; ready_i = 3'b110; #1;
    chk("R6 br0 own ready low", 32'(valid_o[0]), 1);
    ready_i = 3'b111; #1;
    chk("R6 br0 own ready high", 32'(valid_o[0]), 1);
    ready_i = 3'b011; #1;
    chk("R6 br2 own ready low", 32'(valid_o[2]), 1);

    // R4: field placement, independent of handshake
    @(negedge clk);
    valid_i = 1'b0; ready_i = 3'b000; data_i = 24'hA1B2C3; #1;
    chk("R4 branch0 upper", 32'(data_o[23:16]), 32'hA1);
    chk("R4 branch1 middle", 32'(data_o[15:8]), 32'hB2);
    chk("R4 branch2 lower", 32'(data_o[7:0]), 32'hC3);

    // R8: outputs follow inputs mid-cycle, no edge
    @(posedge clk); #3;
    valid_i = 1'b1; ready_i = 3'b111; data_i = 24'h5A_69_F0; #1;
    chk("R8 comb ready_o", 32'(ready_o), 1);
    chk("R8 comb valid_o", 32'(valid_o), 32'h7);
    chk("R8 comb data", 32'(data_o), 32'h5A69F0);
    valid_i = 1'b0; #1;
    chk("R8/R5 comb drop", 32'(valid_o), 0);

    // R8/R3 stream: each bundle to every branch exactly once, same cycle
    for (int i = 0; i < 8; i++) words[i] = 24'(32'h10203 * (i + 1) ^ 32'h00A55A);
    src_idx = 0;
    for (int b = 0; b < N; b++) rcv[b] = 0;
    for (int cyc = 0; cyc < 300 && src_idx < 8; cyc++) begin
      logic [N-1:0] f;
      logic up;
      @(negedge clk);
      ready_i = 3'((cyc * 5 + (cyc >> 1)) ^ (cyc >> 2));
      valid_i = (cyc % 4) != 3;
      data_i  = words[src_idx];
      #1;
      f  = valid_o & ready_i;
      up = valid_i & ready_o;
      if (f != '0 || up)
        chk("R3 all-or-none", {28'(0), f, up}, {28'(0), 3'b111, 1'b1});
      for (int b = 0; b < N; b++) begin
        if (f[b]) begin
          chk("R8 field order", 32'(data_o[(N-1-b)*W +: W]),
              32'(words[rcv[b]][(N-1-b)*W +: W]));
          rcv[b]++;
        end
      end
      @(posedge clk);
      if (up) src_idx++;
    end
    for (int b = 0; b < N; b++) chk("R8 count per branch", 32'(rcv[b]), 8);

    finish_run();
  end
endmodule